// File: doc/BRIEF.md
# Sticky Fault Capture Monitor

This block collects three fault lines that arrive without any timing relation to the system clock. It qualifies each one and records it in two ways. The first record is a status word that firmware reads. Each bit in the word sets when its fault is qualified and clears when firmware reads the word. The second record is a single indicator output. It turns on at the first qualified fault from any source and stays on until the block is reset.

Two of the lines report hardware faults. They mean nothing until the power rail they watch has been enabled for a settling time, about 100 ms at the default settings. The block times this window itself. A two-stage divider makes a 100 Hz single-cycle enable pulse from the 24 MHz system clock. A counter then requires a run of consecutive pulses with the rail enable held high. The third line is a software-reported fault. A firmware control bit gates it. The rail enable and all three fault lines each pass through a two-flop synchronizer. Every register in the block runs on the single system clock.

Top module: `fault_capture_monitor`

## Requirements
- R1: The rail enable and all three fault inputs are resynchronized through two flops. A fault input that rises just after a clock edge sets its status bit at the third following rising edge, and not at the second.
- R2: An internal tick pulses high for exactly one cycle once every DIV_LO*DIV_HI system clock cycles. With the defaults (1000 and 240) this is 100 Hz from 24 MHz.
- R3: `rail_valid_o` goes high only after the synchronized rail enable has stayed high across SETTLE_TICKS consecutive ticks (10 by default). It rises in the cycle after the tick that completes the run.
- R4: When the synchronized rail enable goes low, `rail_valid_o` falls at the next edge and the settle count restarts from zero. A new full window is then needed.
- R5: Hardware faults A and B are qualified only while `rail_valid_o` is high. At other times they do not touch the status word or the indicator.
- R6: The software fault is qualified only while `sw_fault_en_i` is high. At other times it has no effect.
- R7: Status bit 0 records fault A, bit 1 records fault B and bit 2 records the software fault. A bit stays set after its fault goes away. It clears at the edge that samples `stat_rd_i` high.
- R8: If a qualified fault is present in the same cycle as a read, its bit is still set after that read.
- R9: `fault_ind_o` rises together with the first status bit to be set. It then stays high through reads and through any later input activity.
- R10: Reset (active low, synchronous) clears the status word, the indicator, the rail-valid state, the divider counters and the synchronizers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (24 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| rail_en_i | input | 1 | Power rail enable, asynchronous |
| hw_fault_a_i | input | 1 | Hardware fault A, asynchronous |
| hw_fault_b_i | input | 1 | Hardware fault B, asynchronous |
| sw_fault_i | input | 1 | Software-reported fault, asynchronous |
| sw_fault_en_i | input | 1 | Firmware control bit that enables the software fault |
| stat_rd_i | input | 1 | Status read strobe; clears the sticky bits |
| stat_o | output | 3 | Sticky fault status word |
| fault_ind_o | output | 1 | Fault indicator; held until reset |
| rail_valid_o | output | 1 | Rail has settled; hardware faults are qualified |

## Verification
A wrong internal state shows up at the ports within a few cycles, and in one case after a full settling window.

- **Synchronizer fault.** A broken or missing synchronizer stage moves the status update one edge earlier or later than the third-edge point, so the fault latency check catches it on the first fault.
- **Divider or settle-count fault.** Any error in either divider or in the settle counter shifts when `rail_valid_o` rises. The check sees this as the output being high too early or low too late, within one settling window.
- **Capture fault.** A capture bit that does not hold is visible three cycles after its fault goes away. A bit that fails to clear on a read is visible one cycle after the read. A lost read collision or an indicator that drops is visible in the cycle after the read that should have left it alone.

// File: rtl/fcm_pkg.sv
// Package: fcm_pkg
// Purpose : shared constants for the sticky fault capture monitor.
// Assumes : status bit positions are fixed because firmware decodes them.
package fcm_pkg;
    localparam int FAULT_W  = 3;   // number of fault sources / status bits
    localparam int FLT_A    = 0;   // hardware fault A status bit
    localparam int FLT_B    = 1;   // hardware fault B status bit
    localparam int FLT_SW   = 2;   // software fault status bit
    localparam int SYNC_W   = FAULT_W + 1; // faults plus rail enable
    localparam int SYNC_RAIL = FAULT_W;    // rail enable lane in sync bus
endpackage

// File: rtl/fcm_sync.sv
// Module : fcm_sync
// Purpose: multi-stage flop synchronizer for independent single-bit lanes.
// Assumes: every lane is a level signal slow enough to be seen by the
//          system clock; lanes are not treated as a coherent bus.
module fcm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift each lane one flop closer to the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/fcm_tick_gen.sv
// Module : fcm_tick_gen
// Purpose: two-stage divider producing a one-cycle enable pulse every
//          DIV_LO*DIV_HI clock cycles (24 MHz / 1000 / 240 = 100 Hz).
// Assumes: DIV_LO and DIV_HI are both at least 1; the pulse is a clock
//          enable, never used as a clock.
module fcm_tick_gen #(
    parameter int DIV_LO = 1000,
    parameter int DIV_HI = 240
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int LO_W = $clog2(DIV_LO + 1);
    localparam int HI_W = $clog2(DIV_HI + 1);
    localparam logic [LO_W-1:0] LO_LAST = LO_W'(DIV_LO - 1);
    localparam logic [HI_W-1:0] HI_LAST = HI_W'(DIV_HI - 1);

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            lo_wrap;

    assign lo_wrap = (lo_q == LO_LAST);

    // Purpose: first-stage prescaler, wraps every DIV_LO cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_q <= '0;
        else if (lo_wrap) lo_q <= '0;
        else              lo_q <= lo_q + 1'b1;
    end

    // Purpose: second-stage counter, advances once per prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (lo_wrap) begin
            if (hi_q == HI_LAST) hi_q <= '0;
            else                 hi_q <= hi_q + 1'b1;
        end
    end

    assign tick_o = lo_wrap && (hi_q == HI_LAST);
endmodule

// File: rtl/fcm_rail_timer.sv
// Module : fcm_rail_timer
// Purpose: declares the rail valid once the synchronized rail enable has
//          stayed high across SETTLE_TICKS consecutive ticks.
// Assumes: rail_en_i is already in the clock domain; tick_i is one cycle.
module fcm_rail_timer #(
    parameter int SETTLE_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_en_i,
    input  logic tick_i,
    output logic rail_valid_o
);
    localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SETTLE_TICKS);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: count ticks while the rail is on; restart when it drops.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (!rail_en_i)                  cnt_q <= '0;
        else if (tick_i && cnt_q != CNT_DONE) cnt_q <= cnt_q + 1'b1;
    end

    assign rail_valid_o = (cnt_q == CNT_DONE);
endmodule

// File: rtl/fcm_capture.sv
// Module : fcm_capture
// Purpose: qualifies the synchronized faults, holds them in clear-on-read
//          sticky bits and drives an indicator that only reset clears.
// Assumes: fault inputs are synchronized; rd_i is a one-cycle strobe.
module fcm_capture
    import fcm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FAULT_W-1:0] fault_i,
    input  logic               rail_valid_i,
    input  logic               sw_en_i,
    input  logic               rd_i,
    output logic [FAULT_W-1:0] stat_o,
    output logic               ind_o
);
    logic [FAULT_W-1:0] qual;
    logic [FAULT_W-1:0] stat_q;
    logic               ind_q;

    // Purpose: gate each fault with its own qualifier.
    always_comb begin
        qual          = '0;
        qual[FLT_A]   = fault_i[FLT_A]  & rail_valid_i;
        qual[FLT_B]   = fault_i[FLT_B]  & rail_valid_i;
        qual[FLT_SW]  = fault_i[FLT_SW] & sw_en_i;
    end

    genvar b;
    generate
        for (b = 0; b < FAULT_W; b++) begin : g_bit
            // Purpose: sticky bit; a same-cycle fault wins over a read clear.
            always_ff @(posedge clk) begin
                if (!rst_n)       stat_q[b] <= 1'b0;
                else if (qual[b]) stat_q[b] <= 1'b1;
                else if (rd_i)    stat_q[b] <= 1'b0;
            end
        end
    endgenerate

    // Purpose: indicator latch set by any qualified fault, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)     ind_q <= 1'b0;
        else if (|qual) ind_q <= 1'b1;
    end

    assign stat_o = stat_q;
    assign ind_o  = ind_q;
endmodule

// File: rtl/fault_capture_monitor.sv
// Module : fault_capture_monitor
// Purpose: top level; synchronizes the rail enable and fault lines, times
//          the rail settling window and captures qualified faults.
// Assumes: one system clock; sw_fault_en_i and stat_rd_i come from logic
//          already in that clock domain.
module fault_capture_monitor
    import fcm_pkg::*;
#(
    parameter int DIV_LO       = 1000,
    parameter int DIV_HI       = 240,
    parameter int SETTLE_TICKS = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rail_en_i,
    input  logic               hw_fault_a_i,
    input  logic               hw_fault_b_i,
    input  logic               sw_fault_i,
    input  logic               sw_fault_en_i,
    input  logic               stat_rd_i,
    output logic [FAULT_W-1:0] stat_o,
    output logic               fault_ind_o,
    output logic               rail_valid_o
);
    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              tick;
    logic              rail_valid;

    // Purpose: gather the asynchronous lanes in package bit order.
    always_comb begin
        raw_bus            = '0;
        raw_bus[FLT_A]     = hw_fault_a_i;
        raw_bus[FLT_B]     = hw_fault_b_i;
        raw_bus[FLT_SW]    = sw_fault_i;
        raw_bus[SYNC_RAIL] = rail_en_i;
    end

    fcm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bus),
        .sync_o  (sync_bus)
    );

    fcm_tick_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    fcm_rail_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_rail (
        .clk          (clk),
        .rst_n        (rst_n),
        .rail_en_i    (sync_bus[SYNC_RAIL]),
        .tick_i       (tick),
        .rail_valid_o (rail_valid)
    );

    fcm_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_i      (sync_bus[FAULT_W-1:0]),
        .rail_valid_i (rail_valid),
        .sw_en_i      (sw_fault_en_i),
        .rd_i         (stat_rd_i),
        .stat_o       (stat_o),
        .ind_o        (fault_ind_o)
    );

    assign rail_valid_o = rail_valid;
endmodule

// File: rtl/fcm_checker.sv
// Module : fcm_checker
// Purpose: protocol and timing properties of fault_capture_monitor,
//          attached to every instance by the bind below.
// Assumes: tick_i and rail_sync_i are the internal tick and synchronized
//          rail enable of the bound instance.
module fcm_checker
    import fcm_pkg::*;
#(
    parameter int DIV_LO = 1000,
    parameter int DIV_HI = 240
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_i,
    input logic [FAULT_W-1:0] stat_i,
    input logic               ind_i,
    input logic               rail_valid_i,
    input logic               rail_sync_i,
    input logic               tick_i
);
    localparam int PERIOD = DIV_LO * DIV_HI;

    int  gap_q;
    logic seen_q;

    // Purpose: measure tick spacing with a counter instead of a long $past.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (tick_i) begin
            p_tick_period_r2: assert (!seen_q || gap_q == PERIOD - 1)
                else $error("tick spacing %0d, expected %0d", gap_q + 1, PERIOD);
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && PERIOD > 1) |=> !tick_i);

    p_valid_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_valid_i) |-> $past(tick_i));

    p_valid_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_sync_i |=> !rail_valid_i);

    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((stat_i & $past(stat_i)) == $past(stat_i)));

    p_ind_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ind_i |=> ind_i);

    p_stat_implies_ind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_i) |-> ind_i);

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (stat_i == '0 && !ind_i && !rail_valid_i));
endmodule

bind fault_capture_monitor fcm_checker #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_fcm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_i         (stat_rd_i),
    .stat_i       (stat_o),
    .ind_i        (fault_ind_o),
    .rail_valid_i (rail_valid_o),
    .rail_sync_i  (sync_bus[fcm_pkg::SYNC_RAIL]),
    .tick_i       (tick)
);

// File: tb/fault_capture_monitor_test.sv
// Bench for fault_capture_monitor: short dividers (tick every 12 cycles),
// a vector table walked by one loop, then directed corner tests.
module fault_capture_monitor_test;
    localparam int DIV_LO = 4;
    localparam int DIV_HI = 3;
    localparam int SETTLE = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rail_en = 1'b0, fa = 1'b0, fb = 1'b0, fs = 1'b0, sw_en = 1'b0, rd = 1'b0;
    logic [2:0] stat;
    logic       ind, rail_valid;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    fault_capture_monitor #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI),
                            .SETTLE_TICKS(SETTLE), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .rail_en_i(rail_en),
        .hw_fault_a_i(fa), .hw_fault_b_i(fb), .sw_fault_i(fs),
        .sw_fault_en_i(sw_en), .stat_rd_i(rd),
        .stat_o(stat), .fault_ind_o(ind), .rail_valid_o(rail_valid)
    );

    // vector: {fa, fb, fs, sw_en, expected status}
    typedef struct packed { logic a; logic b; logic s; logic en; logic [2:0] exp; } vec_t;
    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 3'b001},
        '{1'b0, 1'b1, 1'b0, 1'b0, 3'b010},
        '{1'b0, 1'b0, 1'b1, 1'b1, 3'b100},
        '{1'b0, 1'b0, 1'b1, 1'b0, 3'b000},
        '{1'b1, 1'b1, 1'b1, 1'b1, 3'b111},
        '{1'b1, 1'b1, 1'b0, 1'b1, 3'b011},
        '{1'b0, 1'b0, 1'b0, 1'b1, 3'b000},
        '{1'b1, 1'b0, 1'b1, 1'b0, 3'b001}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_status();
        rd = 1'b1;
        cyc(1);
        rd = 1'b0;
    endtask

    initial begin
        cyc(5);
        check("R10 reset stat", stat, 0);
        check("R10 reset ind", ind, 0);
        check("R10 reset rail_valid", rail_valid, 0);
        rst_n = 1'b1;

        // hardware fault before the rail is valid
        fa = 1'b1; cyc(6);
        check("R5 hw fault ignored without rail", stat, 0);
        check("R5 ind untouched without rail", ind, 0);
        fa = 1'b0;
        // software fault with enable low
        fs = 1'b1; cyc(6);
        check("R6 sw fault ignored when disabled", stat, 0);
        check("R6 ind untouched when disabled", ind, 0);
        fs = 1'b0; cyc(3);

        // rail settling window: valid between ~112 and ~123 cycles
        rail_en = 1'b1; cyc(100);
        check("R3 rail not valid before window", rail_valid, 0);
        cyc(30);
        check("R3 rail valid after window", rail_valid, 1);

        // synchronizer latency
        fa = 1'b1; cyc(2);
        check("R1 no capture at second edge", stat, 0);
        cyc(1);
        check("R1 capture at third edge", stat, 1);
        check("R9 ind rises with first fault", ind, 1);
        fa = 1'b0; cyc(3);
        read_status();
        check("R7 read clears status", stat, 0);
        check("R9 ind holds through read", ind, 1);

        // vector table
        for (int i = 0; i < 8; i++) begin
            fa = VECS[i].a; fb = VECS[i].b; fs = VECS[i].s; sw_en = VECS[i].en;
            cyc(4);
            check($sformatf("R5/R6/R7 vec %0d capture", i), stat, VECS[i].exp);
            fa = 1'b0; fb = 1'b0; fs = 1'b0;
            cyc(3);
            check($sformatf("R7 vec %0d sticky after release", i), stat, VECS[i].exp);
            read_status();
            check($sformatf("R7 vec %0d cleared by read", i), stat, 0);
            check($sformatf("R9 vec %0d ind held", i), ind, 1);
        end

        // read collides with an active qualified fault
        sw_en = 1'b1; fs = 1'b1; cyc(4);
        read_status();
        check("R8 bit survives colliding read", stat, 4);
        fs = 1'b0; cyc(3);
        read_status();
        check("R8 bit clears on later read", stat, 0);

        // rail drop and restart
        rail_en = 1'b0; cyc(2);
        check("R4 valid still high before sync", rail_valid, 1);
        cyc(1);
        check("R4 valid falls after sync", rail_valid, 0);
        fb = 1'b1; cyc(5);
        check("R5 hw fault B ignored after rail drop", stat, 0);
        fb = 1'b0; cyc(3);
        rail_en = 1'b1; cyc(100);
        check("R4 count restarted from zero", rail_valid, 0);
        cyc(30);
        check("R3 valid again after full window", rail_valid, 1);
        check("R9 ind still held before reset", ind, 1);

        // reset clears everything
        fa = 1'b1; cyc(4);
        rst_n = 1'b0; cyc(2);
        check("R10 reset clears stat", stat, 0);
        check("R10 reset clears ind", ind, 0);
        check("R10 reset clears rail_valid", rail_valid, 0);
        fa = 1'b0; rail_en = 1'b0;
        rst_n = 1'b1; cyc(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule